// File: doc/BRIEF.md
# Central Application Ranking Unit

This block is the central decision point that orders the cores of a many-core chip by how sensitive they are to network delay. A free-running interval timer splits execution into fixed ranking intervals and announces the end of each one with a single-cycle pulse. After that pulse every core sends one report that carries its private-cache miss intensity, measured as misses per instruction. Once the unit holds a report from every core, it sorts the cores. A core with a lower miss intensity is more stall-critical, so it gets a higher rank level.

The sort runs one step per cycle. Each step picks the unranked core with the smallest metric and sends that core its 3-bit rank level on a shared reply port. When there are more cores than the eight rank levels, the sorted positions are folded into eight equal bands, so several cores can share one level. If a core has not reported when the next interval pulse arrives, the sort runs anyway on the cores that did report. The silent core is placed last, gets no reply and keeps its previous rank. The unit also keeps a rank register per core. Each register holds its value until a new reply replaces it.

Top module: `app_rank_unit`

## Requirements
- R1: `interval_end` is high for exactly one cycle every `INTERVAL_CYCLES` cycles.
- R2: After reset, every per-core rank is 0, `rank_valid` is low and `interval_end` is low.
- R3: Rank level 7 is the highest priority. A lower reported metric gives a level that is equal or higher. Replies leave in sorted order, best first, one per cycle on consecutive cycles.
- R4: The reply at sorted position p (starting at 0) carries level 7 − ⌊8·p / NUM_CORES⌋ when NUM_CORES is more than 8, and level 7 − p otherwise.
- R5: Cores with equal metrics are ordered by core ID, lowest ID first.
- R6: As soon as all NUM_CORES cores have reported in the current interval, the sort starts without waiting for the interval pulse. All replies are issued within 2·NUM_CORES + 2 cycles of the last report.
- R7: If some cores have not reported when `interval_end` arrives, the cores that did report are ranked from position 0. The missing cores get no reply and keep their previous rank. No sort starts before that pulse.
- R8: A second report from the same core in one interval is ignored. The first value counts.
- R9: A report presented in the same cycle as `interval_end` is ignored. It counts for neither the closing interval nor the new one.
- R10: Each entry of `core_ranks` changes only in the cycle its core's reply appears on the reply port, and it then equals that reply's level.
- R11: Each core receives at most one reply per interval, and every reply names a core below NUM_CORES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| interval_end | output | 1 | Single-cycle pulse that closes a ranking interval |
| rpt_valid | input | 1 | A metric report is present this cycle |
| rpt_core | input | CORE_ID_W | ID of the reporting core |
| rpt_metric | input | METRIC_W | Misses-per-instruction value of the reporting core |
| rank_valid | output | 1 | A rank reply is present this cycle |
| rank_core | output | CORE_ID_W | ID of the core the reply is for |
| rank_level | output | 3 | Rank level of the reply (7 is the highest priority) |
| core_ranks | output | NUM_CORES*3 | Current rank of every core; core i occupies bits [3i+2:3i] |

## Verification
The sort is driven with strictly distinct metrics given in reverse ID order. Only a correct selection reverses them, and the band boundaries show up as level pairs. A heavily tied pattern separates lowest-ID tie breaking from any other order. A partial report set shows whether a sort starts early and whether silent cores keep their rank. A duplicate report and a report placed exactly on the interval pulse each reveal whether an input that should be ignored slips into the table, because either one would change the reply count or the order.

// File: rtl/app_rank_pkg.sv
package app_rank_pkg;

  // Rank level encoding: 3 bits, the largest value is the highest priority.
  localparam int RANK_W      = 3;
  localparam int RANK_LEVELS = 1 << RANK_W;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_SORT = 1'b1
  } seq_state_e;

endpackage

// File: rtl/rank_interval_timer.sv
module rank_interval_timer #(
  parameter int INTERVAL_CYCLES = 350000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int CNT_W = (INTERVAL_CYCLES > 1) ? $clog2(INTERVAL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rank_report_table.sv
module rank_report_table #(
  parameter int NUM_CORES = 16,
  parameter int METRIC_W  = 16,
  parameter int CORE_ID_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          interval_end,
  input  logic                          rpt_valid,
  input  logic [CORE_ID_W-1:0]          rpt_core,
  input  logic [METRIC_W-1:0]           rpt_metric,
  output logic [NUM_CORES-1:0]          got,
  output logic                          all_got,
  output logic [NUM_CORES*METRIC_W-1:0] metric_flat
);

  logic [NUM_CORES-1:0] got_q;
  logic [NUM_CORES-1:0] got_d;
  logic [NUM_CORES-1:0] wr_en;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_entry
    localparam logic [CORE_ID_W-1:0] MY_ID = CORE_ID_W'(i);
    logic [METRIC_W-1:0] metric_q;

    // A report in the pulse cycle is dropped; only the first report per interval is kept.
    assign wr_en[i] = rpt_valid && !interval_end && !got_q[i] && (rpt_core == MY_ID);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        metric_q <= '0;
      end else if (wr_en[i]) begin
        metric_q <= rpt_metric;
      end
    end

    assign metric_flat[i*METRIC_W +: METRIC_W] = metric_q;
  end

  always_comb begin
    got_d = interval_end ? '0 : (got_q | wr_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q <= '0;
    end else begin
      got_q <= got_d;
    end
  end

  assign got     = got_q;
  assign all_got = &got_q;

endmodule

// File: rtl/rank_min_select.sv
module rank_min_select #(
  parameter int NUM_CORES = 16,
  parameter int METRIC_W  = 16,
  parameter int CORE_ID_W = 4
) (
  input  logic [NUM_CORES-1:0]          cand,
  input  logic [NUM_CORES*METRIC_W-1:0] metric_flat,
  output logic                          found,
  output logic [CORE_ID_W-1:0]          idx
);

  logic [METRIC_W-1:0] best;

  // Strict less-than scanning upward keeps the lowest ID among equal metrics.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (cand[i] && (!found || (metric_flat[i*METRIC_W +: METRIC_W] < best))) begin
        found = 1'b1;
        best  = metric_flat[i*METRIC_W +: METRIC_W];
        idx   = CORE_ID_W'(i);
      end
    end
  end

endmodule

// File: rtl/rank_sequencer.sv
module rank_sequencer
  import app_rank_pkg::*;
#(
  parameter int NUM_CORES = 16,
  parameter int METRIC_W  = 16,
  parameter int CORE_ID_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          interval_end,
  input  logic                          all_got,
  input  logic [NUM_CORES-1:0]          got,
  input  logic [NUM_CORES*METRIC_W-1:0] metric_flat,
  input  logic                          sel_found,
  input  logic [CORE_ID_W-1:0]          sel_idx,
  output logic [NUM_CORES-1:0]          remain,
  output logic [NUM_CORES*METRIC_W-1:0] snap_flat,
  output logic                          rank_valid,
  output logic [CORE_ID_W-1:0]          rank_core,
  output logic [RANK_W-1:0]             rank_level,
  output logic [NUM_CORES*RANK_W-1:0]   core_ranks
);

  localparam int SCALE_W = CORE_ID_W + RANK_W;

  seq_state_e                    state_q, state_d;
  logic                          sorted_q, sorted_d;
  logic [NUM_CORES-1:0]          remain_q, remain_d;
  logic [CORE_ID_W-1:0]          pos_q, pos_d;
  logic [NUM_CORES*METRIC_W-1:0] snap_q;
  logic                          start;
  logic                          step;
  logic [RANK_W-1:0]             band;
  logic [RANK_W-1:0]             pos_level;
  logic                          reply_vld_q;
  logic [CORE_ID_W-1:0]          reply_core_q;
  logic [RANK_W-1:0]             reply_lvl_q;

  // Sorted position to band: fold into equal groups when cores outnumber levels.
  if (NUM_CORES > RANK_LEVELS) begin : g_band_fold
    logic [SCALE_W-1:0] scaled;
    always_comb begin
      scaled = {pos_q, {RANK_W{1'b0}}} / SCALE_W'(NUM_CORES);
      band   = scaled[RANK_W-1:0];
    end
  end else begin : g_band_direct
    always_comb begin
      band = RANK_W'(pos_q);
    end
  end

  assign pos_level = ~band;

  always_comb begin
    start    = (state_q == SEQ_IDLE) && !sorted_q && (all_got || interval_end);
    step     = (state_q == SEQ_SORT) && sel_found;
    state_d  = state_q;
    remain_d = remain_q;
    pos_d    = pos_q;
    sorted_d = interval_end ? 1'b0 : (start ? 1'b1 : sorted_q);
    if (start) begin
      state_d  = SEQ_SORT;
      remain_d = got;
      pos_d    = '0;
    end else if (state_q == SEQ_SORT) begin
      if (sel_found) begin
        remain_d[sel_idx] = 1'b0;
        pos_d             = pos_q + 1'b1;
      end else begin
        state_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      sorted_q <= 1'b0;
      remain_q <= '0;
      pos_q    <= '0;
    end else begin
      state_q  <= state_d;
      sorted_q <= sorted_d;
      remain_q <= remain_d;
      pos_q    <= pos_d;
    end
  end

  // Metric snapshot so new reports can arrive while a pulse-started sort runs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (start) begin
      snap_q <= metric_flat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reply_vld_q <= 1'b0;
    end else begin
      reply_vld_q <= step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reply_core_q <= '0;
      reply_lvl_q  <= '0;
    end else if (step) begin
      reply_core_q <= sel_idx;
      reply_lvl_q  <= pos_level;
    end
  end

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_rank_reg
    localparam logic [CORE_ID_W-1:0] MY_ID = CORE_ID_W'(i);
    logic [RANK_W-1:0] rank_q;
    logic              rank_en;

    assign rank_en = step && (sel_idx == MY_ID);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rank_q <= '0;
      end else if (rank_en) begin
        rank_q <= pos_level;
      end
    end

    assign core_ranks[i*RANK_W +: RANK_W] = rank_q;
  end

  assign remain     = remain_q;
  assign snap_flat  = snap_q;
  assign rank_valid = reply_vld_q;
  assign rank_core  = reply_core_q;
  assign rank_level = reply_lvl_q;

endmodule

// File: rtl/app_rank_unit.sv
module app_rank_unit
  import app_rank_pkg::*;
#(
  parameter int NUM_CORES       = 16,
  parameter int METRIC_W        = 16,
  parameter int INTERVAL_CYCLES = 350000,
  parameter int CORE_ID_W       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  output logic                        interval_end,
  input  logic                        rpt_valid,
  input  logic [CORE_ID_W-1:0]        rpt_core,
  input  logic [METRIC_W-1:0]         rpt_metric,
  output logic                        rank_valid,
  output logic [CORE_ID_W-1:0]        rank_core,
  output logic [RANK_W-1:0]           rank_level,
  output logic [NUM_CORES*RANK_W-1:0] core_ranks
);

  localparam int FLAT_W = NUM_CORES * METRIC_W;

  logic [1:0]           rst_pipe_q;
  logic                 rst_sync_n;
  logic                 tick;
  logic [NUM_CORES-1:0] got;
  logic                 all_got;
  logic [FLAT_W-1:0]    metric_flat;
  logic [NUM_CORES-1:0] remain;
  logic [FLAT_W-1:0]    snap_flat;
  logic                 sel_found;
  logic [CORE_ID_W-1:0] sel_idx;

  // Reset asserts at once and is released two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  rank_interval_timer #(
    .INTERVAL_CYCLES(INTERVAL_CYCLES)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .tick (tick)
  );

  rank_report_table #(
    .NUM_CORES(NUM_CORES),
    .METRIC_W (METRIC_W),
    .CORE_ID_W(CORE_ID_W)
  ) u_table (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .interval_end(tick),
    .rpt_valid   (rpt_valid),
    .rpt_core    (rpt_core),
    .rpt_metric  (rpt_metric),
    .got         (got),
    .all_got     (all_got),
    .metric_flat (metric_flat)
  );

  rank_min_select #(
    .NUM_CORES(NUM_CORES),
    .METRIC_W (METRIC_W),
    .CORE_ID_W(CORE_ID_W)
  ) u_select (
    .cand       (remain),
    .metric_flat(snap_flat),
    .found      (sel_found),
    .idx        (sel_idx)
  );

  rank_sequencer #(
    .NUM_CORES(NUM_CORES),
    .METRIC_W (METRIC_W),
    .CORE_ID_W(CORE_ID_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .interval_end(tick),
    .all_got     (all_got),
    .got         (got),
    .metric_flat (metric_flat),
    .sel_found   (sel_found),
    .sel_idx     (sel_idx),
    .remain      (remain),
    .snap_flat   (snap_flat),
    .rank_valid  (rank_valid),
    .rank_core   (rank_core),
    .rank_level  (rank_level),
    .core_ranks  (core_ranks)
  );

  assign interval_end = tick;

endmodule

// File: rtl/rank_unit_checker.sv
module rank_unit_checker
  import app_rank_pkg::*;
#(
  parameter int NUM_CORES       = 16,
  parameter int INTERVAL_CYCLES = 350000,
  parameter int CORE_ID_W       = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        interval_end,
  input logic                        rank_valid,
  input logic [CORE_ID_W-1:0]        rank_core,
  input logic [RANK_W-1:0]           rank_level,
  input logic [NUM_CORES*RANK_W-1:0] core_ranks
);

  logic [31:0]          gap_q;
  logic [NUM_CORES-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (interval_end) begin
      gap_q <= '0;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (interval_end) begin
      seen_q <= '0;
    end else if (rank_valid) begin
      seen_q[rank_core] <= 1'b1;
    end
  end

  assert_pulse_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    interval_end |-> (gap_q == 32'(INTERVAL_CYCLES - 1)));

  assert_pulse_due_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q == 32'(INTERVAL_CYCLES - 1)) |-> interval_end);

  assert_level_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rank_valid && $past(rank_valid)) |-> (rank_level <= $past(rank_level)));

  assert_ranks_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rank_valid |-> $stable(core_ranks));

  assert_rank_applied_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rank_valid |-> (core_ranks[int'(rank_core)*RANK_W +: RANK_W] == rank_level));

  assert_single_reply_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rank_valid |-> !seen_q[rank_core]);

  assert_core_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rank_valid |-> (int'(rank_core) < NUM_CORES));

endmodule

bind app_rank_unit rank_unit_checker #(
  .NUM_CORES      (NUM_CORES),
  .INTERVAL_CYCLES(INTERVAL_CYCLES),
  .CORE_ID_W      (CORE_ID_W)
) u_rank_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .interval_end(interval_end),
  .rank_valid  (rank_valid),
  .rank_core   (rank_core),
  .rank_level  (rank_level),
  .core_ranks  (core_ranks)
);

// File: tb/app_rank_unit_bench.sv
`timescale 1ns/1ps
module app_rank_unit_bench;

  localparam int NC   = 16;
  localparam int MW   = 16;
  localparam int IW   = 4;
  localparam int IVAL = 400;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             interval_end;
  logic             rpt_valid;
  logic [IW-1:0]    rpt_core;
  logic [MW-1:0]    rpt_metric;
  logic             rank_valid;
  logic [IW-1:0]    rank_core;
  logic [2:0]       rank_level;
  logic [NC*3-1:0]  core_ranks;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int m[NC];
  bit pres[NC];
  int exp_rank[NC];
  int rep_core[64];
  int rep_lvl[64];
  int rep_n = 0;

  always #10 clk = ~clk;

  app_rank_unit #(
    .NUM_CORES(NC), .METRIC_W(MW), .INTERVAL_CYCLES(IVAL), .CORE_ID_W(IW)
  ) u_app_rank_unit (
    .clk(clk), .rst_n(rst_n), .interval_end(interval_end),
    .rpt_valid(rpt_valid), .rpt_core(rpt_core), .rpt_metric(rpt_metric),
    .rank_valid(rank_valid), .rank_core(rank_core), .rank_level(rank_level),
    .core_ranks(core_ranks)
  );

  always @(negedge clk) begin
    if (rst_n === 1'b1 && rank_valid === 1'b1 && rep_n < 64) begin
      rep_core[rep_n] = int'(rank_core);
      rep_lvl[rep_n]  = int'(rank_level);
      rep_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int id, input int val);
    rpt_valid  = 1'b1;
    rpt_core   = IW'(id);
    rpt_metric = MW'(val);
    @(negedge clk);
    rpt_valid  = 1'b0;
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (interval_end !== 1'b1);
  endtask

  task automatic next_interval();
    wait_pulse();
    @(negedge clk);
  endtask

  task automatic send_present();
    for (int i = 0; i < NC; i++) if (pres[i]) send(i, m[i]);
  endtask

  // Reference order: position = number of present cores that beat this one.
  task automatic check_round(input string req);
    int k;
    int pos[NC];
    k = 0;
    for (int i = 0; i < NC; i++) if (pres[i]) k++;
    chk(rep_n == k, {req, " R11 reply count"}, rep_n, k);
    for (int i = 0; i < NC; i++) begin
      pos[i] = 0;
      if (pres[i])
        for (int j = 0; j < NC; j++)
          if (pres[j] && (m[j] < m[i] || (m[j] == m[i] && j < i))) pos[i]++;
    end
    for (int i = 0; i < NC; i++) begin
      if (pres[i]) begin
        exp_rank[i] = 7 - (pos[i] * 8) / NC;
        if (pos[i] < rep_n) begin
          chk(rep_core[pos[i]] == i, {req, " R3/R5 reply order"}, rep_core[pos[i]], i);
          chk(rep_lvl[pos[i]] == exp_rank[i], {req, " R4 reply level"}, rep_lvl[pos[i]], exp_rank[i]);
        end
      end
    end
    for (int i = 0; i < NC; i++)
      chk(int'(core_ranks[i*3 +: 3]) == exp_rank[i], {req, " R10 core rank"},
          int'(core_ranks[i*3 +: 3]), exp_rank[i]);
  endtask

  task automatic t_reset();  // R2
    chk(rank_valid == 1'b0, "R2 rank_valid", int'(rank_valid), 0);
    chk(core_ranks == '0, "R2 core_ranks", int'(core_ranks != '0), 0);
    chk(interval_end == 1'b0, "R2 interval_end", int'(interval_end), 0);
    for (int i = 0; i < NC; i++) exp_rank[i] = 0;
  endtask

  task automatic t_period();  // R1
    int n;
    wait_pulse();
    n = 0;
    do begin @(negedge clk); n++; end while (interval_end !== 1'b1);
    chk(n == IVAL, "R1 pulse period", n, IVAL);
    @(negedge clk);
    chk(interval_end == 1'b0, "R1 pulse width", int'(interval_end), 0);
  endtask

  task automatic t_full_order();  // R3 R4 R6
    next_interval();
    rep_n = 0;
    for (int i = 0; i < NC; i++) begin pres[i] = 1; m[i] = 1000 - 50 * i; end
    send_present();
    repeat (2 * NC + 2) @(negedge clk);
    chk(rep_n == NC, "R6 early sort complete", rep_n, NC);
    check_round("R3 distinct");
  endtask

  task automatic t_ties();  // R5
    next_interval();
    rep_n = 0;
    for (int i = 0; i < NC; i++) begin pres[i] = 1; m[i] = (i % 4) * 10; end
    send_present();
    repeat (40) @(negedge clk);
    check_round("R5 ties");
  endtask

  task automatic t_duplicate();  // R8
    next_interval();
    rep_n = 0;
    for (int i = 0; i < NC; i++) begin pres[i] = 1; m[i] = 7 * i + 100; end
    m[3] = 900;
    send(3, 900);
    send(3, 0);
    for (int i = 0; i < NC; i++) if (i != 3) send(i, m[i]);
    repeat (40) @(negedge clk);
    check_round("R8 duplicate");
  endtask

  task automatic t_missing();  // R7
    next_interval();
    rep_n = 0;
    for (int i = 0; i < NC; i++) begin pres[i] = (i % 3 != 0); m[i] = 500 - 20 * i; end
    send_present();
    repeat (40) @(negedge clk);
    chk(rep_n == 0, "R7 no sort before pulse", rep_n, 0);
    wait_pulse();
    repeat (40) @(negedge clk);
    check_round("R7 partial");
  endtask

  task automatic t_pulse_edge();  // R9
    next_interval();
    rep_n = 0;
    for (int i = 0; i < NC; i++) begin pres[i] = (i != 5); m[i] = 3 * i + 2; end
    send_present();
    wait_pulse();
    send(5, 0);  // presented during the pulse cycle
    repeat (40) @(negedge clk);
    check_round("R9 closing interval");
    rep_n = 0;
    for (int i = 0; i < NC; i++) m[i] = (15 - i) * 4;
    send_present();
    repeat (40) @(negedge clk);
    chk(rep_n == 0, "R9 pulse-cycle report not counted", rep_n, 0);
    wait_pulse();
    repeat (40) @(negedge clk);
    check_round("R9 next interval");
  endtask

  initial begin
    rst_n = 1'b0;
    rpt_valid = 1'b0;
    rpt_core = '0;
    rpt_metric = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_period();
    t_full_order();
    t_ties();
    t_duplicate();
    t_missing();
    t_pulse_edge();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule